// File: doc/BRIEF.md
# Cascaded CAM Device Select and Status Slice

This block is the control slice of one content-addressable memory device in a daisy chain of identical devices. For every bus cycle (command write, data write, command read or data read) it decides whether this device answers. The decision uses a 16-bit select register, the device's own page address, the chain inputs for full and match, and the device's own full and match flags. The memory array and its compare logic are outside the block. Their results arrive as strobes. A compare strobe carries hit, multiple-hit and the best address. A memory-read strobe carries the skip and empty validity bits of the location read.

Devices are chained by wiring each full output to the next device's full input, and each match output to the next device's match input. The first device has its full input tied low and its match input tied high. A select value of all ones broadcasts to every device. Writes and instructions aimed at the next free location land only in the first device that still has room. The block also keeps the next-free address, which counts up as that device fills. It also keeps a 32-bit status word, the default source for command reads.

Top module: `cam_chain_select`

## Requirements
- R1: After reset the status word holds bits 31..27 all one, the page field equal to `PAGE_INIT`, the match-address field all ones, and every other bit zero. After reset `nf_addr` is 0, `resp` is 0, `full_out_n` is 1 and the select register holds FFFFh.
- R2: Cycle kind is encoded on `cyc_kind` as 0 = command write, 1 = data write, 2 = command read, 3 = data read. Command ops are encoded on `cyc_op` as 0 = other, 1 = load select, 2 = load page, 3 = set full, 4 = move to next free, 5 = move to best match, 6 = next-free output, 7 = set persistent destination. The device is selected when the select register is FFFFh or when it equals the page address. Command writes with op 0, 6 or 7, and plain command reads, are answered only when the device is selected.
- R3: A load-select command write (op 1) is answered by every device, and every device stores `cyc_wdata` as its new select value, whatever the current selection. A set-persistent-destination write (op 7) stores `cyc_wdata[1:0]` in every device: 0 = comparand, 1 = memory at next free, 2 = memory at best match.
- R4: A load-page write (op 2) and a set-full write (op 3) are answered, and take effect, only in the first-free device, meaning `full_in_n` low and the device not full.
- R5: A move to next free (op 4), and a data write while the persistent destination is next free, are answered only by the first-free device. Each one advances that device's `nf_addr` by one. The write at address DEPTH-1 sets the full flag instead, and the flag stays set until reset.
- R6: `full_out_n` is low exactly when `full_in_n` is low and the device is full.
- R7: After a next-free-output command (op 6), the next command read is answered only by the first-free device. Later command reads follow R2 again.
- R8: A data read is answered only when the device is selected. When the select register is FFFFh, it is further limited to the device whose own match is active and whose `match_in_n` is high. `match_out_n` is low when `match_in_n` is low or this device's match is active.
- R9: When `match_en` is 0, the device's match is treated as inactive. This blocks the responses of R8 and R10 and drives `match_out_n` from `match_in_n` alone.
- R10: A move to best match (op 5), and a data write while the persistent destination is best match, are answered only by a selected device whose match is active.
- R11: A compare strobe updates the status word. Bit 31 = NOT hit, and bit 30 = NOT (hit AND multi). The low AW bits take the compare address on a hit and all ones on a miss. Bit 29 = NOT full.
- R12: A memory-read strobe loads status bit 28 from `mem_skip` and bit 27 from `mem_empty`.
- R13: `resp` is a register: it shows the decision for a cycle presented with `cyc_vld` high in the clock after the edge that sampled it, and it is 0 for idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | A bus cycle is presented this clock |
| cyc_kind | input | 2 | Cycle kind, see R2 |
| cyc_op | input | 3 | Command op for command writes, see R2 |
| cyc_wdata | input | 16 | Write data for select, page and destination loads |
| match_en | input | 1 | Match-flag function enable |
| full_in_n | input | 1 | Chain full input, low when every upstream device is full |
| match_in_n | input | 1 | Chain match input, low when an upstream device matched |
| cmp_vld | input | 1 | Compare result strobe |
| cmp_hit | input | 1 | Compare found a match |
| cmp_multi | input | 1 | Compare found more than one match |
| cmp_addr | input | AW | Best match address |
| mem_vld | input | 1 | Memory read or move strobe |
| mem_skip | input | 1 | Skip bit of the location read |
| mem_empty | input | 1 | Empty bit of the location read |
| resp | output | 1 | Registered response of this device |
| full_out_n | output | 1 | Chain full output |
| match_out_n | output | 1 | Chain match output |
| nf_addr | output | AW | Next free address |
| status_word | output | 32 | Status word |

## Verification
Every result of this block is due one clock edge after its stimulus. `resp`, `nf_addr`, the full flag, the select, page and destination registers, and the status fields are all loaded at the edge that samples the cycle or strobe. The chain outputs then follow combinationally from that new state. The bench drives each stimulus on a falling edge and holds it across exactly one rising edge. It reads every output at the next falling edge, before any further stimulus. Three instances are chained, so each next-free operation is checked to be answered by exactly one device.

// File: rtl/cam_sel_pkg.sv
package cam_sel_pkg;
  localparam int SEL_W = 16;

  typedef enum logic [1:0] {
    CYC_CMD_WR = 2'd0,
    CYC_DAT_WR = 2'd1,
    CYC_CMD_RD = 2'd2,
    CYC_DAT_RD = 2'd3
  } cyc_kind_e;

  typedef enum logic [2:0] {
    OP_OTHER   = 3'd0,
    OP_LD_SEL  = 3'd1,
    OP_LD_PAGE = 3'd2,
    OP_SET_FUL = 3'd3,
    OP_MOV_NF  = 3'd4,
    OP_MOV_BM  = 3'd5,
    OP_NF_OUT  = 3'd6,
    OP_SET_DST = 3'd7
  } cmd_op_e;

  typedef enum logic [1:0] {
    DST_CMP = 2'd0,
    DST_NF  = 2'd1,
    DST_BM  = 2'd2
  } dest_e;

  // Broadcast value or own page address selects the device.
  function automatic logic dev_selected(logic [SEL_W-1:0] sel_q,
                                        logic [SEL_W-1:0] page_q);
    return (sel_q == {SEL_W{1'b1}}) || (sel_q == page_q);
  endfunction

  // First device with room: upstream all full, this one not full.
  function automatic logic is_first_free(logic fin_n, logic full_q);
    return !fin_n && !full_q;
  endfunction
endpackage

// File: rtl/cam_sel_decode.sv
module cam_sel_decode
  import cam_sel_pkg::*;
(
  input  logic             vld,
  input  cyc_kind_e        kind,
  input  cmd_op_e          op,
  input  dest_e            pdest,
  input  logic             nf_out_pend,
  input  logic [SEL_W-1:0] sel_q,
  input  logic [SEL_W-1:0] page_q,
  input  logic             full_in_n,
  input  logic             full_q,
  input  logic             match_in_n,
  input  logic             match_q,
  input  logic             match_en,
  output logic             respond,
  output logic             first_free,
  output logic             match_act
);
  logic sel_hit;
  logic bcast;

  assign sel_hit    = dev_selected(sel_q, page_q);
  assign bcast      = (sel_q == {SEL_W{1'b1}});
  assign first_free = is_first_free(full_in_n, full_q);
  assign match_act  = match_en && match_q;

  always_comb begin
    respond = 1'b0;
    if (vld) begin
      unique case (kind)
        CYC_CMD_WR: begin
          unique case (op)
            OP_LD_SEL:              respond = 1'b1;
            OP_LD_PAGE, OP_SET_FUL,
            OP_MOV_NF:              respond = first_free;
            OP_MOV_BM:              respond = sel_hit && match_act;
            default:                respond = sel_hit;
          endcase
        end
        CYC_DAT_WR: begin
          unique case (pdest)
            DST_NF:  respond = first_free;
            DST_BM:  respond = sel_hit && match_act;
            default: respond = sel_hit;
          endcase
        end
        CYC_CMD_RD: respond = nf_out_pend ? first_free : sel_hit;
        default:    respond = bcast ? (match_act && match_in_n) : sel_hit;
      endcase
    end
  end
endmodule

// File: rtl/cam_sel_alloc.sv
module cam_sel_alloc #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          set_full,
  output logic [AW-1:0] nf_addr,
  output logic          full_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nf_addr <= '0;
      full_q  <= 1'b0;
    end else begin
      if (set_full) full_q <= 1'b1;
      if (adv) begin
        if (nf_addr == LAST) full_q <= 1'b1;
        else                 nf_addr <= nf_addr + 1'b1;
      end
    end
  end

  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |=> full_q); // R5
  AST_NF_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_addr != $past(nf_addr)) |-> (nf_addr == $past(nf_addr) + 1'b1)); // R5
  AST_NF_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(nf_addr)); // R5
endmodule

// File: rtl/cam_sel_status.sv
module cam_sel_status
  import cam_sel_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_vld,
  input  logic             cmp_hit,
  input  logic             cmp_multi,
  input  logic [AW-1:0]    cmp_addr,
  input  logic             mem_vld,
  input  logic             mem_skip,
  input  logic             mem_empty,
  input  logic [SEL_W-1:0] page_q,
  input  logic             full_q,
  output logic             match_q,
  output logic [31:0]      status_word
);
  logic          multi_q;
  logic          skip_q;
  logic          empty_q;
  logic [AW-1:0] best_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      best_q  <= '1;
      skip_q  <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      if (cmp_vld) begin
        match_q <= cmp_hit;
        multi_q <= cmp_hit && cmp_multi;
        best_q  <= cmp_hit ? cmp_addr : '1;
      end
      if (mem_vld) begin
        skip_q  <= mem_skip;
        empty_q <= mem_empty;
      end
    end
  end

  always_comb begin
    status_word                 = '0;
    status_word[31]             = !match_q;
    status_word[30]             = !multi_q;
    status_word[29]             = !full_q;
    status_word[28]             = skip_q;
    status_word[27]             = empty_q;
    status_word[AW+SEL_W-1:AW]  = page_q;
    status_word[AW-1:0]         = best_q;
  end

  AST_MISS_ADDR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !match_q |-> (best_q == {AW{1'b1}})); // R11
  AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    multi_q |-> match_q); // R11
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_vld |=> ($stable(skip_q) && $stable(empty_q))); // R12
endmodule

// File: rtl/cam_chain_select.sv
module cam_chain_select
  import cam_sel_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter logic [15:0] PAGE_INIT = 16'h0000,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_vld,
  input  logic [1:0]    cyc_kind,
  input  logic [2:0]    cyc_op,
  input  logic [15:0]   cyc_wdata,
  input  logic          match_en,
  input  logic          full_in_n,
  input  logic          match_in_n,
  input  logic          cmp_vld,
  input  logic          cmp_hit,
  input  logic          cmp_multi,
  input  logic [AW-1:0] cmp_addr,
  input  logic          mem_vld,
  input  logic          mem_skip,
  input  logic          mem_empty,
  output logic          resp,
  output logic          full_out_n,
  output logic          match_out_n,
  output logic [AW-1:0] nf_addr,
  output logic [31:0]   status_word
);
  cyc_kind_e        kind;
  cmd_op_e          op;
  dest_e            pdest_q;
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] page_q;
  logic             nf_out_pend;
  logic             full_q;
  logic             match_q;
  logic             respond;
  logic             first_free;
  logic             match_act;
  logic             cmd_wr;
  logic             ld_sel_ev;
  logic             ld_page_ev;
  logic             set_full_ev;
  logic             adv_ev;

  assign kind = cyc_kind_e'(cyc_kind);
  assign op   = cmd_op_e'(cyc_op);

  cam_sel_decode u_decode (
    .vld        (cyc_vld),
    .kind       (kind),
    .op         (op),
    .pdest      (pdest_q),
    .nf_out_pend(nf_out_pend),
    .sel_q      (sel_q),
    .page_q     (page_q),
    .full_in_n  (full_in_n),
    .full_q     (full_q),
    .match_in_n (match_in_n),
    .match_q    (match_q),
    .match_en   (match_en),
    .respond    (respond),
    .first_free (first_free),
    .match_act  (match_act)
  );

  // Named internal events for the assertions.
  assign cmd_wr      = cyc_vld && (kind == CYC_CMD_WR);
  assign ld_sel_ev   = cmd_wr && (op == OP_LD_SEL);
  assign ld_page_ev  = cmd_wr && (op == OP_LD_PAGE) && first_free;
  assign set_full_ev = cmd_wr && (op == OP_SET_FUL) && first_free;
  assign adv_ev      = first_free &&
                       ((cmd_wr && (op == OP_MOV_NF)) ||
                        (cyc_vld && (kind == CYC_DAT_WR) && (pdest_q == DST_NF)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '1;
      page_q      <= PAGE_INIT;
      pdest_q     <= DST_CMP;
      nf_out_pend <= 1'b0;
      resp        <= 1'b0;
    end else begin
      resp <= respond;
      if (ld_sel_ev)  sel_q  <= cyc_wdata;
      if (ld_page_ev) page_q <= cyc_wdata;
      if (cmd_wr && (op == OP_SET_DST)) pdest_q <= dest_e'(cyc_wdata[1:0]);
      if (cmd_wr && (op == OP_NF_OUT))  nf_out_pend <= 1'b1;
      else if (cyc_vld && (kind == CYC_CMD_RD)) nf_out_pend <= 1'b0;
    end
  end

  cam_sel_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv_ev),
    .set_full(set_full_ev),
    .nf_addr (nf_addr),
    .full_q  (full_q)
  );

  cam_sel_status #(.AW(AW)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_vld    (cmp_vld),
    .cmp_hit    (cmp_hit),
    .cmp_multi  (cmp_multi),
    .cmp_addr   (cmp_addr),
    .mem_vld    (mem_vld),
    .mem_skip   (mem_skip),
    .mem_empty  (mem_empty),
    .page_q     (page_q),
    .full_q     (full_q),
    .match_q    (match_q),
    .status_word(status_word)
  );

  assign full_out_n  = !(!full_in_n && full_q);
  assign match_out_n = match_in_n && !match_act;

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_vld |=> !resp); // R13
  AST_LD_SEL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sel_ev |=> (resp && (sel_q == $past(cyc_wdata)))); // R3
  AST_NF_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_addr != $past(nf_addr)) |-> !$past(full_in_n)); // R5
  AST_PAGE_FIRST_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q != $past(page_q)) |-> (!$past(full_in_n) && $past(full_out_n))); // R4
  AST_NO_MATCH_NO_BCAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && (kind == CYC_DAT_RD) && !match_en && (sel_q == {SEL_W{1'b1}}))
      |=> !resp); // R9
endmodule

// File: tb/cam_chain_select_tb_top.sv
module cam_chain_select_tb_top;
  localparam int ND = 3;
  localparam int DEPTH = 4;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cyc_vld = 0;
  logic [1:0]  cyc_kind = 0;
  logic [2:0]  cyc_op = 0;
  logic [15:0] cyc_wdata = 0;
  logic        match_en = 1;
  logic        mem_vld = 0, mem_skip = 0, mem_empty = 0;
  logic        cmp_vld [ND];
  logic        cmp_hit [ND];
  logic        cmp_multi [ND];
  logic [AW-1:0] cmp_addr [ND];
  logic        fi_n [ND];
  logic        mi_n [ND];
  logic        resp [ND];
  logic        ff_n [ND];
  logic        mo_n [ND];
  logic [AW-1:0] nfa [ND];
  logic [31:0] st [ND];

  int checks = 0;
  int fails = 0;

  for (genvar g = 0; g < ND; g++) begin : g_dev
    if (g == 0) begin : g_head
      assign fi_n[g] = 1'b0;
      assign mi_n[g] = 1'b1;
    end else begin : g_link
      assign fi_n[g] = ff_n[g-1];
      assign mi_n[g] = mo_n[g-1];
    end
    cam_chain_select #(.DEPTH(DEPTH), .PAGE_INIT(16'(g))) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_kind(cyc_kind),
      .cyc_op(cyc_op), .cyc_wdata(cyc_wdata), .match_en(match_en),
      .full_in_n(fi_n[g]), .match_in_n(mi_n[g]), .cmp_vld(cmp_vld[g]),
      .cmp_hit(cmp_hit[g]), .cmp_multi(cmp_multi[g]), .cmp_addr(cmp_addr[g]),
      .mem_vld(mem_vld), .mem_skip(mem_skip), .mem_empty(mem_empty),
      .resp(resp[g]), .full_out_n(ff_n[g]), .match_out_n(mo_n[g]),
      .nf_addr(nfa[g]), .status_word(st[g]));
  end

  function automatic logic [31:0] exp_st(bit mf, bit mm, bit fl, bit sk, bit em,
                                         logic [15:0] pg, logic [AW-1:0] ad);
    return {!mf, !mm, !fl, sk, em, 9'b0, pg, ad};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] resp_vec();
    return {resp[2], resp[1], resp[0]};
  endfunction

  task automatic cyc(logic [1:0] k, logic [2:0] o, logic [15:0] d);
    @(negedge clk);
    cyc_vld = 1; cyc_kind = k; cyc_op = o; cyc_wdata = d;
    @(negedge clk);
    cyc_vld = 0; cyc_op = 0; cyc_wdata = 0;
  endtask

  task automatic cmp(int dev, bit hit, bit multi, logic [AW-1:0] a);
    @(negedge clk);
    cmp_vld[dev] = 1; cmp_hit[dev] = hit; cmp_multi[dev] = multi; cmp_addr[dev] = a;
    @(negedge clk);
    cmp_vld[dev] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    for (int i = 0; i < ND; i++) begin
      chk("R1", "status", st[i], exp_st(0, 0, 0, 1, 1, 16'(i), '1));
      chk("R1", "nf_addr", 32'(nfa[i]), 0);
      chk("R6", "full_out_n", 32'(ff_n[i]), 1);
    end
    chk("R1", "resp", 32'(resp_vec()), 0);
    cyc(2, 0, 0);
    chk("R13", "broadcast cmd read after reset", 32'(resp_vec()), 3'b111);
    @(negedge clk);
    chk("R13", "idle cycle resp", 32'(resp_vec()), 0);
  endtask

  task automatic t_page_full();
    cyc(0, 2, 16'h0009);
    chk("R4", "page write resp", 32'(resp_vec()), 3'b001);
    chk("R4", "dev0 page", st[0], exp_st(0, 0, 0, 1, 1, 16'h0009, '1));
    chk("R4", "dev1 page untouched", st[1], exp_st(0, 0, 0, 1, 1, 16'h0001, '1));
    cyc(0, 3, 0);
    chk("R4", "set full resp", 32'(resp_vec()), 3'b001);
    chk("R6", "chain full outs", 32'({ff_n[2], ff_n[1], ff_n[0]}), 3'b110);
    chk("R11", "dev0 full bit", st[0], exp_st(0, 0, 1, 1, 1, 16'h0009, '1));
    cyc(0, 2, 16'h000A);
    chk("R4", "second page write resp", 32'(resp_vec()), 3'b010);
    chk("R4", "dev1 page", st[1], exp_st(0, 0, 0, 1, 1, 16'h000A, '1));
    cyc(0, 1, 16'h0009);
    chk("R3", "load select all respond", 32'(resp_vec()), 3'b111);
    cyc(2, 0, 0);
    chk("R2", "page-select cmd read", 32'(resp_vec()), 3'b001);
    cyc(0, 1, 16'h0007);
    cyc(2, 0, 0);
    chk("R2", "no page matches", 32'(resp_vec()), 3'b000);
    cyc(0, 1, 16'hFFFF);
    chk("R3", "load select when none selected", 32'(resp_vec()), 3'b111);
    do_reset();
  endtask

  task automatic t_next_free();
    cyc(0, 7, 16'h0001);
    chk("R3", "set dest all", 32'(resp_vec()), 3'b111);
    for (int n = 1; n <= DEPTH; n++) begin
      cyc(1, 0, 16'h1234);
      chk("R5", "nf data write only dev0", 32'(resp_vec()), 3'b001);
      chk("R5", "dev0 nf_addr", 32'(nfa[0]), (n < DEPTH) ? n : DEPTH - 1);
    end
    chk("R6", "dev0 full out", 32'({ff_n[2], ff_n[1], ff_n[0]}), 3'b110);
    chk("R5", "dev1 untouched", 32'(nfa[1]), 0);
    cyc(1, 0, 16'h1234);
    chk("R5", "nf write moves to dev1", 32'(resp_vec()), 3'b010);
    chk("R5", "dev1 nf_addr", 32'(nfa[1]), 1);
    cyc(0, 4, 0);
    chk("R5", "move to next free", 32'(resp_vec()), 3'b010);
    chk("R5", "dev1 nf_addr after move", 32'(nfa[1]), 2);
    cyc(0, 6, 0);
    chk("R2", "nf output cmd selected", 32'(resp_vec()), 3'b111);
    cyc(2, 0, 0);
    chk("R7", "read after nf output", 32'(resp_vec()), 3'b010);
    cyc(2, 0, 0);
    chk("R7", "following read broadcast", 32'(resp_vec()), 3'b111);
    cyc(0, 7, 16'h0000);
  endtask

  task automatic t_match();
    cmp(0, 0, 0, 0);
    cmp(1, 1, 0, 2'd2);
    cmp(2, 1, 1, 2'd3);
    chk("R11", "dev0 miss", st[0], exp_st(0, 0, 1, 1, 1, 16'h0, '1));
    chk("R11", "dev1 hit", st[1], exp_st(1, 0, 0, 1, 1, 16'h1, 2'd2));
    chk("R11", "dev2 multi", st[2], exp_st(1, 1, 0, 1, 1, 16'h2, 2'd3));
    chk("R8", "match chain", 32'({mo_n[2], mo_n[1], mo_n[0]}), 3'b001);
    cyc(3, 0, 0);
    chk("R8", "broadcast data read", 32'(resp_vec()), 3'b010);
    cyc(0, 5, 0);
    chk("R10", "move to best match", 32'(resp_vec()), 3'b110);
    cyc(0, 7, 16'h0002);
    cyc(1, 0, 0);
    chk("R10", "data write to best match", 32'(resp_vec()), 3'b110);
    match_en = 0;
    cyc(3, 0, 0);
    chk("R9", "read blocked", 32'(resp_vec()), 3'b000);
    cyc(0, 5, 0);
    chk("R9", "move blocked", 32'(resp_vec()), 3'b000);
    chk("R9", "match chain idle", 32'({mo_n[2], mo_n[1], mo_n[0]}), 3'b111);
    match_en = 1;
    cyc(0, 1, 16'h0002);
    cyc(3, 0, 0);
    chk("R8", "page data read", 32'(resp_vec()), 3'b100);
    cmp(1, 0, 1, 2'd1);
    chk("R11", "dev1 no match", st[1], exp_st(0, 0, 0, 1, 1, 16'h1, '1));
  endtask

  task automatic t_valid();
    @(negedge clk);
    mem_vld = 1; mem_skip = 0; mem_empty = 1;
    @(negedge clk);
    mem_vld = 0; mem_skip = 1; mem_empty = 0;
    chk("R12", "skip/empty loaded", 32'(st[2][28:27]), 2'b01);
    @(negedge clk);
    chk("R12", "skip/empty held", 32'(st[2][28:27]), 2'b01);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin
      cmp_vld[i] = 0; cmp_hit[i] = 0; cmp_multi[i] = 0; cmp_addr[i] = 0;
    end
    do_reset();
    t_reset();
    t_page_full();
    t_next_free();
    t_match();
    t_valid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule